// File: doc/BRIEF.md
# Cuckoo hash table engine

This block keeps key/value pairs in a table with one slot per address, and it gives every key two possible homes. Two XOR-fold hash functions compute the two homes. A requester issues one operation at a time (find, insert or remove) with a key and, for inserts, a value. The engine answers with a one-cycle response carrying a hit flag, a status code and, for a successful find, the stored value. The table is a single-port memory with registered reads. The engine drives it with one slot access per cycle.

A find never touches more than the two candidate slots, so its cost is fixed. An insert first checks both homes for the key and updates it in place if it is found. Otherwise the new entry takes its first home. Any occupant there is pushed to its other home, and that can push out another entry, and so on. The chain is capped by a parameter. When the cap is reached, the entry that still has no slot is parked in a spill register, and the requester is told that the table needs rebuilding.

The table works best while fewer than half of its slots are in use. Rebuilding with new hash functions is the requester's job.

Top module: `cuckoo_engine`

## Requirements
- R1: The two candidate slots of a key are computed from fixed-size pieces of the key, each piece ADDR_W bits wide, where piece n holds key bits [n*ADDR_W +: ADDR_W].
  - The first slot is the XOR of all the pieces.
  - The second slot is the XOR of every piece rotated left by (n mod ADDR_W), then XORed with HASH_SALT.
  - With the defaults (16-bit key, 4-bit slot index, salt 4'h9), key 16'h0012 maps to slots 3 and 9. Key 16'h0021 maps to slots 3 and 12. Keys 16'h0000, 16'h00FF and 16'h0505 all map to slots 0 and 9.
- R2: Operation codes are find = 0, insert = 1, remove = 2, and code 3 behaves as find.
  - A find of a stored key responds with status OK (0), hit = 1 and the stored value.
  - A find of an absent key responds with status MISS (1), hit = 0 and value 0.
  - A find answers on the first clock edge after acceptance when the key sits in its first slot. Otherwise it answers on the second edge, and never later.
- R3: Inserting a key that is absent, when its first slot is free, stores the key there. The response has status OK and hit = 0.
- R4: Inserting a key that is already stored, in either candidate slot, overwrites its value in that same slot. It moves no entry, and the response has status OK and hit = 1.
- R5: Inserting an absent key whose first slot is taken places the new entry in that slot. The former occupant is moved to its other candidate slot, and each further displaced entry moves the same way until one lands in a free slot. The response then has status OK and hit = 0.
- R6: An insert makes at most MAX_KICKS displacements (default 16). If the entry displaced last finds its other slot taken, it is not written to the table. Instead it is loaded into the spill outputs (spill_valid = 1, with its key and value), and the response has status FULL (2) and hit = 0. Every other entry stays findable. The spill outputs hold until the next failing insert or reset.
- R7: Removing a stored key frees its slot, and the response has status OK and hit = 1. Removing an absent key responds with status MISS and hit = 0.
- R8: A synchronous active-low reset empties every slot, drops rsp_valid and spill_valid, and leaves req_ready high.
- R9: A request is taken on a clock edge where req_valid and req_ready are both high.
  - req_ready is low from the taking edge until the response.
  - Each taken request produces exactly one response pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_op | input | 2 | 0 find, 1 insert, 2 remove, 3 find |
| req_key | input | KEY_W | Key of the request |
| req_val | input | VAL_W | Value for an insert |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Key was found |
| rsp_status | output | 2 | 0 OK, 1 MISS, 2 FULL |
| rsp_val | output | VAL_W | Value returned by a successful find, else 0 |
| spill_valid | output | 1 | Spill register holds an entry left without a slot |
| spill_key | output | KEY_W | Key of the spilled entry |
| spill_val | output | VAL_W | Value of the spilled entry |

## Verification
The assertions check the following on every cycle:
- the engine goes busy after taking a request, and responses are single-cycle pulses;
- a find never enters the displacement loop, and a hit always carries status OK;
- the displacement counter stays within MAX_KICKS;
- FULL is only reported for an insert, with the spill register loaded.

Only the bench scenarios can show the rest:
- which slot a key lands in, and the find latency that follows from it;
- that an in-place update moves nothing;
- that a chain among three keys sharing both slots ends with the right key spilled and the other two still found;
- that reset empties the table.

// File: rtl/cuckoo_pkg.sv
// Shared encodings for the cuckoo hash engine: request operations,
// response status codes and controller states. Assumes 2-bit op/status
// fields at the block edge.
package cuckoo_pkg;

    typedef enum logic [1:0] {
        OP_FIND = 2'd0,
        OP_PUT  = 2'd1,
        OP_DROP = 2'd2,
        OP_ALT  = 2'd3
    } ck_op_e;

    typedef enum logic [1:0] {
        RS_OK   = 2'd0,
        RS_MISS = 2'd1,
        RS_FULL = 2'd2
    } ck_status_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_PROBE0,
        CS_PROBE1,
        CS_KREAD,
        CS_KPLACE
    } ck_state_e;

endpackage

// File: rtl/cuckoo_hash.sv
// One of the two slot hash functions. SEL = 0 gives a plain XOR fold of
// the key's ADDR_W-bit pieces; SEL = 1 rotates piece n left by n mod
// ADDR_W before folding and then XORs a salt. Purely combinational.
// Assumes KEY_W >= ADDR_W; a short last piece is zero padded.
module cuckoo_hash #(
    parameter int              KEY_W  = 16,
    parameter int              ADDR_W = 4,
    parameter int              SEL    = 0,
    parameter logic [ADDR_W-1:0] SALT = '0
) (
    input  logic [KEY_W-1:0]  key_i,
    output logic [ADDR_W-1:0] slot_o
);

    generate
        if (SEL == 0) begin : g_plain
            // Fold every key bit onto its position within a piece.
            always_comb begin
                slot_o = '0;
                for (int i = 0; i < KEY_W; i++) begin
                    slot_o[i % ADDR_W] = slot_o[i % ADDR_W] ^ key_i[i];
                end
            end
        end else begin : g_rotated
            // Fold with each piece rotated by its index, then salt.
            always_comb begin
                slot_o = SALT;
                for (int i = 0; i < KEY_W; i++) begin
                    slot_o[((i % ADDR_W) + (i / ADDR_W)) % ADDR_W] =
                        slot_o[((i % ADDR_W) + (i / ADDR_W)) % ADDR_W] ^ key_i[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cuckoo_store.sv
// Single-port slot memory: each cycle either writes one slot or reads one
// slot into registered outputs (read data appears after the next edge).
// Valid bits are cleared by the synchronous active-low reset; key and
// value storage is not reset. Assumes the caller never uses read data in
// the cycle after a write.
module cuckoo_store #(
    parameter int KEY_W  = 16,
    parameter int VAL_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wvalid,
    input  logic [KEY_W-1:0]  wkey,
    input  logic [VAL_W-1:0]  wval,
    output logic              rvalid,
    output logic [KEY_W-1:0]  rkey,
    output logic [VAL_W-1:0]  rval
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] vld;
    logic [KEY_W-1:0] key_mem [DEPTH];
    logic [VAL_W-1:0] val_mem [DEPTH];

    // Occupancy flags: cleared on reset, set or cleared by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (we) begin
            vld[addr] <= wvalid;
        end
    end

    // Key and value storage, written with the flag.
    always_ff @(posedge clk) begin
        if (we) begin
            key_mem[addr] <= wkey;
            val_mem[addr] <= wval;
        end
    end

    // Registered read port, updated only on read cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rkey   <= '0;
            rval   <= '0;
        end else if (!we) begin
            rvalid <= vld[addr];
            rkey   <= key_mem[addr];
            rval   <= val_mem[addr];
        end
    end

endmodule

// File: rtl/cuckoo_ctrl.sv
// Operation sequencer: probes the two candidate slots, answers finds and
// removes, updates or places inserts, and runs the bounded displacement
// chain with a spill register for the entry left over. Drives the slot
// memory one access per cycle and the hash input mux. Assumes
// MAX_KICKS >= 1 and a memory with one cycle of read latency.
module cuckoo_ctrl
    import cuckoo_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int VAL_W     = 16,
    parameter int ADDR_W    = 4,
    parameter int MAX_KICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [VAL_W-1:0]  req_val,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_status,
    output logic [VAL_W-1:0]  rsp_val,
    output logic              spill_valid,
    output logic [KEY_W-1:0]  spill_key,
    output logic [VAL_W-1:0]  spill_val,
    output logic [KEY_W-1:0]  hash_key,
    input  logic [ADDR_W-1:0] hash0,
    input  logic [ADDR_W-1:0] hash1,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_wvalid,
    output logic [KEY_W-1:0]  mem_wkey,
    output logic [VAL_W-1:0]  mem_wval,
    input  logic              mem_rvalid,
    input  logic [KEY_W-1:0]  mem_rkey,
    input  logic [VAL_W-1:0]  mem_rval
);

    localparam int                KICK_W     = $clog2(MAX_KICKS + 1);
    localparam logic [KICK_W-1:0] KICK_LIMIT = KICK_W'(MAX_KICKS);

    ck_state_e         state;
    ck_op_e            op_q;
    logic [KEY_W-1:0]  key_q;
    logic [VAL_W-1:0]  val_q;
    logic [ADDR_W-1:0] h0_q;
    logic [ADDR_W-1:0] h1_q;
    logic              slot0_vld;
    logic [KEY_W-1:0]  slot0_key;
    logic [VAL_W-1:0]  slot0_val;
    logic [KEY_W-1:0]  car_key;
    logic [VAL_W-1:0]  car_val;
    logic [ADDR_W-1:0] cur_slot;
    logic [ADDR_W-1:0] tgt_slot;
    logic [KICK_W-1:0] kick_cnt;

    logic              accept;
    logic              rd_match;
    logic              is_put;
    logic              is_drop;
    logic [ADDR_W-1:0] alt_slot;

    // Handshake and decode helpers.
    always_comb begin
        req_ready = (state == CS_IDLE);
        accept    = req_valid && req_ready;
        rd_match  = mem_rvalid && (mem_rkey == key_q);
        is_put    = (op_q == OP_PUT);
        is_drop   = (op_q == OP_DROP);
        hash_key  = (state == CS_IDLE) ? req_key : car_key;
        alt_slot  = (cur_slot == hash0) ? hash1 : hash0;
    end

    // Memory port: one read or one write per cycle, chosen by state.
    always_comb begin
        mem_addr   = hash0;
        mem_we     = 1'b0;
        mem_wvalid = 1'b1;
        mem_wkey   = key_q;
        mem_wval   = val_q;
        case (state)
            CS_IDLE: mem_addr = hash0;
            CS_PROBE0: begin
                mem_addr = h1_q;
                if (rd_match && (is_put || is_drop)) begin
                    mem_we     = 1'b1;
                    mem_addr   = h0_q;
                    mem_wvalid = is_put;
                end
            end
            CS_PROBE1: begin
                mem_addr = h0_q;
                if (rd_match && (is_put || is_drop)) begin
                    mem_we     = 1'b1;
                    mem_addr   = h1_q;
                    mem_wvalid = is_put;
                end else if (!rd_match && is_put) begin
                    mem_we = 1'b1;
                end
            end
            CS_KREAD: mem_addr = alt_slot;
            CS_KPLACE: begin
                mem_addr = tgt_slot;
                mem_wkey = car_key;
                mem_wval = car_val;
                mem_we   = !(mem_rvalid && (kick_cnt == KICK_LIMIT));
            end
            default: mem_addr = hash0;
        endcase
    end

    // Sequencer state, request capture, chain bookkeeping and responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= CS_IDLE;
            op_q        <= OP_FIND;
            key_q       <= '0;
            val_q       <= '0;
            h0_q        <= '0;
            h1_q        <= '0;
            slot0_vld   <= 1'b0;
            slot0_key   <= '0;
            slot0_val   <= '0;
            car_key     <= '0;
            car_val     <= '0;
            cur_slot    <= '0;
            tgt_slot    <= '0;
            kick_cnt    <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_status  <= RS_OK;
            rsp_val     <= '0;
            spill_valid <= 1'b0;
            spill_key   <= '0;
            spill_val   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                CS_IDLE: begin
                    if (accept) begin
                        op_q  <= ck_op_e'(req_op);
                        key_q <= req_key;
                        val_q <= req_val;
                        h0_q  <= hash0;
                        h1_q  <= hash1;
                        state <= CS_PROBE0;
                    end
                end
                CS_PROBE0: begin
                    slot0_vld <= mem_rvalid;
                    slot0_key <= mem_rkey;
                    slot0_val <= mem_rval;
                    if (rd_match) begin
                        rsp_valid  <= 1'b1;
                        rsp_hit    <= 1'b1;
                        rsp_status <= RS_OK;
                        rsp_val    <= (is_put || is_drop) ? '0 : mem_rval;
                        state      <= CS_IDLE;
                    end else begin
                        state <= CS_PROBE1;
                    end
                end
                CS_PROBE1: begin
                    if (rd_match) begin
                        rsp_valid  <= 1'b1;
                        rsp_hit    <= 1'b1;
                        rsp_status <= RS_OK;
                        rsp_val    <= (is_put || is_drop) ? '0 : mem_rval;
                        state      <= CS_IDLE;
                    end else if (!is_put) begin
                        rsp_valid  <= 1'b1;
                        rsp_hit    <= 1'b0;
                        rsp_status <= RS_MISS;
                        rsp_val    <= '0;
                        state      <= CS_IDLE;
                    end else if (!slot0_vld) begin
                        rsp_valid  <= 1'b1;
                        rsp_hit    <= 1'b0;
                        rsp_status <= RS_OK;
                        rsp_val    <= '0;
                        state      <= CS_IDLE;
                    end else begin
                        car_key  <= slot0_key;
                        car_val  <= slot0_val;
                        cur_slot <= h0_q;
                        kick_cnt <= KICK_W'(1);
                        state    <= CS_KREAD;
                    end
                end
                CS_KREAD: begin
                    tgt_slot <= alt_slot;
                    state    <= CS_KPLACE;
                end
                CS_KPLACE: begin
                    if (!mem_rvalid) begin
                        rsp_valid  <= 1'b1;
                        rsp_hit    <= 1'b0;
                        rsp_status <= RS_OK;
                        rsp_val    <= '0;
                        state      <= CS_IDLE;
                    end else if (kick_cnt == KICK_LIMIT) begin
                        spill_valid <= 1'b1;
                        spill_key   <= car_key;
                        spill_val   <= car_val;
                        rsp_valid   <= 1'b1;
                        rsp_hit     <= 1'b0;
                        rsp_status  <= RS_FULL;
                        rsp_val     <= '0;
                        state       <= CS_IDLE;
                    end else begin
                        car_key  <= mem_rkey;
                        car_val  <= mem_rval;
                        cur_slot <= tgt_slot;
                        kick_cnt <= kick_cnt + KICK_W'(1);
                        state    <= CS_KREAD;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    kick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_KPLACE) |-> (kick_cnt != '0 && kick_cnt <= KICK_LIMIT));

    // R6
    full_only_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == RS_FULL) |-> (op_q == OP_PUT && spill_valid));

    // R2
    find_two_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_KREAD) |-> (op_q == OP_PUT));

    // R2
    hit_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_status == RS_OK));

endmodule

// File: rtl/cuckoo_engine.sv
// Top of the cuckoo hash engine: two hash units (plain and rotated fold)
// feeding the sequencer, which drives a single-port slot memory. Table
// depth is 2**ADDR_W. One request is in flight at a time.
module cuckoo_engine #(
    parameter int              KEY_W     = 16,
    parameter int              VAL_W     = 16,
    parameter int              ADDR_W    = 4,
    parameter int              MAX_KICKS = 16,
    parameter logic [ADDR_W-1:0] HASH_SALT = ADDR_W'(9)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [KEY_W-1:0] req_key,
    input  logic [VAL_W-1:0] req_val,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [1:0]       rsp_status,
    output logic [VAL_W-1:0] rsp_val,
    output logic             spill_valid,
    output logic [KEY_W-1:0] spill_key,
    output logic [VAL_W-1:0] spill_val
);

    logic [KEY_W-1:0]  hash_key;
    logic [ADDR_W-1:0] hash_w [2];
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic              mem_wvalid;
    logic [KEY_W-1:0]  mem_wkey;
    logic [VAL_W-1:0]  mem_wval;
    logic              mem_rvalid;
    logic [KEY_W-1:0]  mem_rkey;
    logic [VAL_W-1:0]  mem_rval;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_hash
            cuckoo_hash #(
                .KEY_W (KEY_W),
                .ADDR_W(ADDR_W),
                .SEL   (g),
                .SALT  ((g == 0) ? '0 : HASH_SALT)
            ) u_hash (
                .key_i (hash_key),
                .slot_o(hash_w[g])
            );
        end
    endgenerate

    cuckoo_ctrl #(
        .KEY_W    (KEY_W),
        .VAL_W    (VAL_W),
        .ADDR_W   (ADDR_W),
        .MAX_KICKS(MAX_KICKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_key    (req_key),
        .req_val    (req_val),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_status (rsp_status),
        .rsp_val    (rsp_val),
        .spill_valid(spill_valid),
        .spill_key  (spill_key),
        .spill_val  (spill_val),
        .hash_key   (hash_key),
        .hash0      (hash_w[0]),
        .hash1      (hash_w[1]),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wvalid (mem_wvalid),
        .mem_wkey   (mem_wkey),
        .mem_wval   (mem_wval),
        .mem_rvalid (mem_rvalid),
        .mem_rkey   (mem_rkey),
        .mem_rval   (mem_rval)
    );

    cuckoo_store #(
        .KEY_W (KEY_W),
        .VAL_W (VAL_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .we    (mem_we),
        .wvalid(mem_wvalid),
        .wkey  (mem_wkey),
        .wval  (mem_wval),
        .rvalid(mem_rvalid),
        .rkey  (mem_rkey),
        .rval  (mem_rval)
    );

endmodule

// File: tb/cuckoo_engine_test.sv
// Bench for the cuckoo hash engine: a vector table of operations with
// expected responses, then directed tests for reset, a capped
// displacement chain with spill, and reset of a filled table.
module cuckoo_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] key;
        logic [15:0] val;
        logic [1:0]  st;
        logic        hit;
        logic [15:0] rv;
        logic [1:0]  lat;
    } vec_t;

    // op key val status hit value latency(0 = not checked)
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 16'h0012, 16'h0000, 2'd1, 1'b0, 16'h0000, 2'd2},
        '{2'd1, 16'h0012, 16'h1111, 2'd0, 1'b0, 16'h0000, 2'd0},
        '{2'd0, 16'h0012, 16'h0000, 2'd0, 1'b1, 16'h1111, 2'd1},
        '{2'd1, 16'h0012, 16'h2222, 2'd0, 1'b1, 16'h0000, 2'd0},
        '{2'd3, 16'h0012, 16'h0000, 2'd0, 1'b1, 16'h2222, 2'd1},
        '{2'd1, 16'h0021, 16'h3333, 2'd0, 1'b0, 16'h0000, 2'd0},
        '{2'd0, 16'h0021, 16'h0000, 2'd0, 1'b1, 16'h3333, 2'd1},
        '{2'd0, 16'h0012, 16'h0000, 2'd0, 1'b1, 16'h2222, 2'd2},
        '{2'd2, 16'h0012, 16'h0000, 2'd0, 1'b1, 16'h0000, 2'd0},
        '{2'd0, 16'h0012, 16'h0000, 2'd1, 1'b0, 16'h0000, 2'd2},
        '{2'd2, 16'h0012, 16'h0000, 2'd1, 1'b0, 16'h0000, 2'd0},
        '{2'd0, 16'h0021, 16'h0000, 2'd0, 1'b1, 16'h3333, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_key = '0;
    logic [15:0] req_val = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_status;
    logic [15:0] rsp_val;
    logic        spill_valid;
    logic [15:0] spill_key;
    logic [15:0] spill_val;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [1:0]  got_st;
    logic        got_hit;
    logic [15:0] got_val;
    int          got_lat;

    cuckoo_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_key    (req_key),
        .req_val    (req_val),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_status (rsp_status),
        .rsp_val    (rsp_val),
        .spill_valid(spill_valid),
        .spill_key  (spill_key),
        .spill_val  (spill_val)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string vec_tag(input int idx);
        case (idx)
            1:       return "R3";
            3, 4:    return "R4";
            5, 6, 7: return "R5";
            8, 9, 10: return "R7";
            default: return "R2";
        endcase
    endfunction

    // Issue one request, wait for its response and capture it.
    task automatic do_req(input logic [1:0] op, input logic [15:0] key,
                          input logic [15:0] val);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_key   = key;
        req_val   = val;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R9 busy after acceptance
        chk(req_ready == 1'b0, "R9", "ready after accept", 32'(req_ready), 32'd0);
        got_lat = 0;
        for (int w = 0; w < 200; w++) begin
            @(posedge clk);
            got_lat++;
            @(negedge clk);
            if (rsp_valid) break;
        end
        got_st  = rsp_status;
        got_hit = rsp_hit;
        got_val = rsp_val;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready in reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk(spill_valid == 1'b0, "R8", "spill in reset", 32'(spill_valid), 32'd0);
        rst_n = 1'b1;

        // Vector walk: R1 slot mapping drives the expected latencies.
        for (int i = 0; i < NVEC; i++) begin
            do_req(VEC[i].op, VEC[i].key, VEC[i].val);
            chk(got_st == VEC[i].st, vec_tag(i), $sformatf("vec %0d status", i),
                32'(got_st), 32'(VEC[i].st));
            chk(got_hit == VEC[i].hit, vec_tag(i), $sformatf("vec %0d hit", i),
                32'(got_hit), 32'(VEC[i].hit));
            chk(got_val == VEC[i].rv, vec_tag(i), $sformatf("vec %0d value", i),
                32'(got_val), 32'(VEC[i].rv));
            if (VEC[i].lat != 2'd0) begin
                // R2 fixed probe cost, R1 first slot gives latency 1
                chk(got_lat == int'(VEC[i].lat), "R2", $sformatf("vec %0d latency", i),
                    32'(got_lat), 32'(VEC[i].lat));
            end
        end

        // R9 one-cycle response pulse and ready again
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", "pulse width", 32'(rsp_valid), 32'd0);
        chk(req_ready == 1'b1, "R9", "ready after rsp", 32'(req_ready), 32'd1);

        // R6 three keys sharing slots 0 and 9 (R1): third insert spills
        do_req(2'd1, 16'h0000, 16'hAAAA);
        chk(got_st == 2'd0, "R3", "A insert status", 32'(got_st), 32'd0);
        do_req(2'd1, 16'h00FF, 16'hBBBB);
        chk(got_st == 2'd0, "R5", "B insert status", 32'(got_st), 32'd0);
        do_req(2'd1, 16'h0505, 16'hCCCC);
        chk(got_st == 2'd2, "R6", "C insert status", 32'(got_st), 32'd2);
        chk(got_hit == 1'b0, "R6", "C insert hit", 32'(got_hit), 32'd0);
        chk(spill_valid == 1'b1, "R6", "spill valid", 32'(spill_valid), 32'd1);
        chk(spill_key == 16'h00FF, "R6", "spill key", 32'(spill_key), 32'h00FF);
        chk(spill_val == 16'hBBBB, "R6", "spill value", 32'(spill_val), 32'hBBBB);
        do_req(2'd0, 16'h0000, 16'h0);
        chk(got_hit && got_val == 16'hAAAA, "R6", "A still found",
            32'(got_val), 32'hAAAA);
        do_req(2'd0, 16'h0505, 16'h0);
        chk(got_hit && got_val == 16'hCCCC, "R6", "C still found",
            32'(got_val), 32'hCCCC);
        do_req(2'd0, 16'h00FF, 16'h0);
        chk(got_st == 2'd1, "R6", "spilled key not in table", 32'(got_st), 32'd1);
        do_req(2'd0, 16'h0021, 16'h0);
        chk(got_hit && got_val == 16'h3333, "R6", "unrelated key kept",
            32'(got_val), 32'h3333);
        chk(spill_valid == 1'b1, "R6", "spill held", 32'(spill_valid), 32'd1);

        // R8 reset of a filled table empties it and clears spill
        apply_reset();
        @(negedge clk);
        chk(spill_valid == 1'b0, "R8", "spill after reset", 32'(spill_valid), 32'd0);
        chk(req_ready == 1'b1, "R8", "ready after reset", 32'(req_ready), 32'd1);
        do_req(2'd0, 16'h0021, 16'h0);
        chk(got_st == 2'd1 && !got_hit, "R8", "table empty after reset",
            32'(got_st), 32'd1);
        do_req(2'd0, 16'h0000, 16'h0);
        chk(got_st == 2'd1, "R8", "slot 0 empty after reset", 32'(got_st), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule